// File: doc/BRIEF.md
# Interrupt-driven character port

This block connects a keyboard and a display to a processor through three memory-mapped registers on a small register bus. The processor reaches them with ordinary loads and stores. A keyboard-side strobe leaves a character in the receive register and raises a receive-ready flag. A display-side acknowledge raises a transmit-ready flag, which shows that the display can take another character.

Software can poll the status register. It waits for the receive-ready flag and then reads the receive register. It waits for the transmit-ready flag and then writes the transmit register. Software can instead set the interrupt-enable bit, and the block then holds a level interrupt request for as long as a character waits unread. Reading the receive register clears its flag, and writing the transmit register clears the transmit flag.

The bus read path is combinational from registers. An access takes effect at the clock edge that ends the cycle in which the read or write strobe is high. The asynchronous reset is released through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `kbio_port`

## Requirements
- R1: After reset, the interrupt enable is 0, the receive-ready flag is 0, the transmit-ready flag is 1 and `irq` is low, so a read of the status register returns 0x01.
- R2: Word address 0 selects the receive register, 1 selects the transmit register, 2 selects the status register, and 3 reads as zero. In the status register the transmit-ready flag is bit 0, the receive-ready flag is bit 1 and the interrupt enable is bit 6. Every other bit, and every data bit above the 8-bit character, reads as zero. `bus_rdata` is zero when `bus_rd` is low.
- R3: A cycle with `key_stb` high loads `key_char` into the receive register and sets the receive-ready flag at that edge.
- R4: A read at address 0 returns the stored character and clears the receive-ready flag at the same edge. The character itself stays in the register.
- R5: When `key_stb` and a read at address 0 fall in the same cycle, the read returns the old character. The new character is stored and the receive-ready flag stays set.
- R6: A write at address 1 stores the low 8 bits, drives them on `disp_char`, makes them readable at address 1, and clears the transmit-ready flag.
- R7: `disp_ack` sets the transmit-ready flag. If a write at address 1 falls in the same cycle, the write wins and the flag ends at 0.
- R8: A write at address 2 loads only the interrupt enable, from data bit 6: 0x40 enables and 0x00 disables. The two ready flags ignore status writes. Writes at address 0 or 3 change nothing.
- R9: `irq` is high exactly while the interrupt enable and the receive-ready flag are both 1. It stays high until a receive read or a disabling status write removes the condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word address of the register access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| key_stb | input | 1 | Keyboard character-valid strobe |
| key_char | input | 8 | Keyboard character |
| disp_ack | input | 1 | Display has accepted the pending character |
| disp_char | output | 8 | Character last written for the display |
| irq | output | 1 | Level interrupt request |

## Verification
The bench puts a keyboard strobe in the same cycle as a receive read. A design that lets the clear win would lose the new character's ready flag, and the test status read would show bit 1 at 0. It also puts a display acknowledge on the same cycle as a transmit write. A design where the acknowledge wins would report the display ready while a character is still pending. Status writes with every bit but 6 set check that the ready flags cannot be forced from software. Writes to the receive register and to the unused address check that neither leaks into stored state. The interrupt line is checked while it is enabled with no data waiting, after a read drains the data, and after software disables it. An implementation that latched the request, or ignored the enable, would fail one of those checks.

// File: rtl/kbio_pkg.sv
package kbio_pkg;
  // word offsets of the three registers
  localparam int unsigned OFS_RXD  = 0;
  localparam int unsigned OFS_TXD  = 1;
  localparam int unsigned OFS_STAT = 2;
  // status bit positions
  localparam int unsigned BIT_TXRDY = 0;
  localparam int unsigned BIT_RXRDY = 1;
  localparam int unsigned BIT_IEN   = 6;

  // decoded one-cycle register accesses
  typedef struct packed {
    logic rd_rxd;
    logic wr_txd;
    logic wr_stat;
  } kbio_acc_t;
endpackage

// File: rtl/kbio_decode.sv
module kbio_decode
  import kbio_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output kbio_acc_t         acc
);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(OFS_RXD);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(OFS_TXD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  always_comb begin
    acc         = '0;
    acc.rd_rxd  = rd && (addr == A_RXD);
    acc.wr_txd  = wr && (addr == A_TXD);
    acc.wr_stat = wr && (addr == A_STAT);
  end
endmodule

// File: rtl/kbio_rx.sv
module kbio_rx #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              rd_clr,
  output logic [CHAR_W-1:0] data_q,
  output logic              rdy_q
);
  logic rdy_d;
  logic load_en;

  // a new strobe outranks the clear from a read in the same cycle
  always_comb begin
    load_en = stb;
    rdy_d   = rdy_q;
    if (stb)         rdy_d = 1'b1;
    else if (rd_clr) rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      data_q <= '0;
    end else begin
      rdy_q <= rdy_d;
      if (load_en) data_q <= char_in;
    end
  end
endmodule

// File: rtl/kbio_tx.sv
module kbio_tx #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              ack,
  output logic [CHAR_W-1:0] data_q,
  output logic              rdy_q
);
  logic rdy_d;
  logic load_en;

  // a pending write outranks an acknowledge in the same cycle
  always_comb begin
    load_en = wr;
    rdy_d   = rdy_q;
    if (wr)       rdy_d = 1'b0;
    else if (ack) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b1;
      data_q <= '0;
    end else begin
      rdy_q <= rdy_d;
      if (load_en) data_q <= char_in;
    end
  end
endmodule

// File: rtl/kbio_ctl.sv
module kbio_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stat,
  input  logic ien_bit,
  input  logic rx_rdy,
  output logic ien_q,
  output logic irq
);
  logic ien_d;

  always_comb begin
    ien_d = ien_q;
    if (wr_stat) ien_d = ien_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= 1'b0;
    else        ien_q <= ien_d;
  end

  assign irq = ien_q & rx_rdy;
endmodule

// File: rtl/kbio_rdmux.sv
module kbio_rdmux
  import kbio_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CHAR_W-1:0] rxd,
  input  logic [CHAR_W-1:0] txd,
  input  logic              rx_rdy,
  input  logic              tx_rdy,
  input  logic              ien,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - CHAR_W;

  logic [DATA_W-1:0] rxd_ext;
  logic [DATA_W-1:0] txd_ext;
  logic [DATA_W-1:0] stat_w;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rxd_ext = {{PAD_W{1'b0}}, rxd};
      assign txd_ext = {{PAD_W{1'b0}}, txd};
    end else begin : g_nopad
      assign rxd_ext = rxd;
      assign txd_ext = txd;
    end
  endgenerate

  always_comb begin
    stat_w            = '0;
    stat_w[BIT_TXRDY] = tx_rdy;
    stat_w[BIT_RXRDY] = rx_rdy;
    stat_w[BIT_IEN]   = ien;
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if      (addr == ADDR_W'(OFS_RXD))  rdata = rxd_ext;
      else if (addr == ADDR_W'(OFS_TXD))  rdata = txd_ext;
      else if (addr == ADDR_W'(OFS_STAT)) rdata = stat_w;
    end
  end
endmodule

// File: rtl/kbio_port.sv
module kbio_port
  import kbio_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              key_stb,
  input  logic [CHAR_W-1:0] key_char,
  input  logic              disp_ack,
  output logic [CHAR_W-1:0] disp_char,
  output logic              irq
);
  logic [1:0]        rst_sync_q;
  logic              run_n;
  kbio_acc_t         acc;
  logic [CHAR_W-1:0] rxd_q;
  logic [CHAR_W-1:0] txd_q;
  logic              rx_rdy_q;
  logic              tx_rdy_q;
  logic              ien_q;

  // reset asserts at once and is released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run_n = rst_sync_q[1];

  kbio_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .acc  (acc)
  );

  kbio_rx #(.CHAR_W(CHAR_W)) u_rx (
    .clk     (clk),
    .rst_n   (run_n),
    .stb     (key_stb),
    .char_in (key_char),
    .rd_clr  (acc.rd_rxd),
    .data_q  (rxd_q),
    .rdy_q   (rx_rdy_q)
  );

  kbio_tx #(.CHAR_W(CHAR_W)) u_tx (
    .clk     (clk),
    .rst_n   (run_n),
    .wr      (acc.wr_txd),
    .char_in (bus_wdata[CHAR_W-1:0]),
    .ack     (disp_ack),
    .data_q  (txd_q),
    .rdy_q   (tx_rdy_q)
  );

  kbio_ctl u_ctl (
    .clk     (clk),
    .rst_n   (run_n),
    .wr_stat (acc.wr_stat),
    .ien_bit (bus_wdata[BIT_IEN]),
    .rx_rdy  (rx_rdy_q),
    .ien_q   (ien_q),
    .irq     (irq)
  );

  kbio_rdmux #(.DATA_W(DATA_W), .CHAR_W(CHAR_W), .ADDR_W(ADDR_W)) u_rmux (
    .rd     (bus_rd),
    .addr   (bus_addr),
    .rxd    (rxd_q),
    .txd    (txd_q),
    .rx_rdy (rx_rdy_q),
    .tx_rdy (tx_rdy_q),
    .ien    (ien_q),
    .rdata  (bus_rdata)
  );

  assign disp_char = txd_q;
endmodule

// File: rtl/kbio_port_chk.sv
module kbio_port_chk #(
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              run_n,
  input logic              key_stb,
  input logic [CHAR_W-1:0] key_char,
  input logic              rd_rxd,
  input logic              wr_txd,
  input logic              wr_stat,
  input logic              ien_bit,
  input logic [CHAR_W-1:0] wchar,
  input logic              disp_ack,
  input logic [CHAR_W-1:0] rxd,
  input logic [CHAR_W-1:0] disp_char,
  input logic              rx_rdy,
  input logic              tx_rdy,
  input logic              ien,
  input logic              irq
);
  // R3
  key_load_chk: assert property (@(posedge clk) disable iff (!run_n)
    key_stb |=> (rx_rdy && rxd == $past(key_char)));

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!run_n)
    (rd_rxd && !key_stb) |=> (!rx_rdy && $stable(rxd)));

  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!run_n)
    (!key_stb && !rd_rxd) |=> ($stable(rx_rdy) && $stable(rxd)));

  // R6
  tx_write_chk: assert property (@(posedge clk) disable iff (!run_n)
    wr_txd |=> (!tx_rdy && disp_char == $past(wchar)));

  // R7
  tx_ack_chk: assert property (@(posedge clk) disable iff (!run_n)
    (disp_ack && !wr_txd) |=> tx_rdy);

  // R8
  ien_load_chk: assert property (@(posedge clk) disable iff (!run_n)
    wr_stat |=> (ien == $past(ien_bit)));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!run_n)
    (irq && !rd_rxd && !(wr_stat && !ien_bit)) |=> irq);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!run_n)
    (!ien || !rx_rdy) |-> !irq);
endmodule

bind kbio_port kbio_port_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk       (clk),
  .run_n     (run_n),
  .key_stb   (key_stb),
  .key_char  (key_char),
  .rd_rxd    (acc.rd_rxd),
  .wr_txd    (acc.wr_txd),
  .wr_stat   (acc.wr_stat),
  .ien_bit   (bus_wdata[kbio_pkg::BIT_IEN]),
  .wchar     (bus_wdata[CHAR_W-1:0]),
  .disp_ack  (disp_ack),
  .rxd       (rxd_q),
  .disp_char (disp_char),
  .rx_rdy    (rx_rdy_q),
  .tx_rdy    (tx_rdy_q),
  .ien       (ien_q),
  .irq       (irq)
);

// File: tb/kbio_port_bench.sv
`timescale 1ns/1ps
module kbio_port_bench;
  localparam int DW = 32;
  localparam int CW = 8;
  localparam int AW = 2;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_KEY = 2'd2;
  localparam logic [1:0] OP_ACK = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [1:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic       exp_irq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  2'd2, 8'h00, 8'h01, 1'b0, 4'd1},  // R1 R2 reset status
    '{OP_KEY, 2'd0, 8'h41, 8'h00, 1'b0, 4'd3},
    '{OP_RD,  2'd2, 8'h00, 8'h03, 1'b0, 4'd3},  // R3 rx ready, R9 masked
    '{OP_WR,  2'd2, 8'h40, 8'h00, 1'b0, 4'd8},
    '{OP_RD,  2'd2, 8'h00, 8'h43, 1'b1, 4'd8},  // R8 enable, R9 irq up
    '{OP_RD,  2'd0, 8'h00, 8'h41, 1'b1, 4'd4},  // R4 char read
    '{OP_RD,  2'd2, 8'h00, 8'h41, 1'b0, 4'd9},  // R4 flag cleared, R9 irq down
    '{OP_RD,  2'd0, 8'h00, 8'h41, 1'b0, 4'd4},  // R4 char held
    '{OP_WR,  2'd1, 8'h5A, 8'h00, 1'b0, 4'd6},
    '{OP_RD,  2'd2, 8'h00, 8'h40, 1'b0, 4'd6},  // R6 tx busy
    '{OP_RD,  2'd1, 8'h00, 8'h5A, 1'b0, 4'd6},  // R6 readback
    '{OP_ACK, 2'd0, 8'h00, 8'h00, 1'b0, 4'd7},
    '{OP_RD,  2'd2, 8'h00, 8'h41, 1'b0, 4'd7},  // R7 tx ready again
    '{OP_WR,  2'd2, 8'hBF, 8'h00, 1'b0, 4'd8},
    '{OP_RD,  2'd2, 8'h00, 8'h01, 1'b0, 4'd8},  // R8 only bit 6 counts
    '{OP_WR,  2'd0, 8'h77, 8'h00, 1'b0, 4'd8},
    '{OP_RD,  2'd0, 8'h00, 8'h41, 1'b0, 4'd8},  // R8 rx write ignored
    '{OP_WR,  2'd3, 8'hFF, 8'h00, 1'b0, 4'd2},
    '{OP_RD,  2'd3, 8'h00, 8'h00, 1'b0, 4'd2},  // R2 unused address
    '{OP_RD,  2'd2, 8'h00, 8'h01, 1'b0, 4'd8},  // R8 addr 3 write ignored
    '{OP_KEY, 2'd0, 8'h0D, 8'h00, 1'b0, 4'd3},
    '{OP_RD,  2'd2, 8'h00, 8'h03, 1'b0, 4'd9},  // R9 held off while disabled
    '{OP_WR,  2'd2, 8'h40, 8'h00, 1'b0, 4'd8},
    '{OP_RD,  2'd2, 8'h00, 8'h43, 1'b1, 4'd9},  // R9 irq once enabled
    '{OP_WR,  2'd2, 8'h00, 8'h00, 1'b0, 4'd8},
    '{OP_RD,  2'd2, 8'h00, 8'h03, 1'b0, 4'd9},  // R9 disable drops irq
    '{OP_RD,  2'd0, 8'h00, 8'h0D, 1'b0, 4'd3}   // R3 new char stored
  };

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_rd;
  logic          bus_wr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          key_stb;
  logic [CW-1:0] key_char;
  logic          disp_ack;
  logic [CW-1:0] disp_char;
  logic          irq;

  int checks;
  int errors;
  bit done;

  kbio_port u_kbio_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .key_stb   (key_stb),
    .key_char  (key_char),
    .disp_ack  (disp_ack),
    .disp_char (disp_char),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    key_stb = 1'b0; key_char = '0; disp_ack = 1'b0;
  endtask

  // called just after a falling edge; one cycle per call
  task automatic finish_cycle();
    @(negedge clk);
    idle();
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    bus_rd = 1'b1; bus_addr = a;
    #1 chk(req, bus_rdata, DW'(exp));
    finish_cycle();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = DW'(d);
    finish_cycle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 20000 && !done; wd++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    do_reset();

    // R1 reset state seen at the ports
    #1 chk("R1 irq", DW'(irq), DW'(0));
    chk("R1 disp_char", DW'(disp_char), DW'(0));
    chk("R2 rdata idle", bus_rdata, '0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      case (v.op)
        OP_WR: wr(v.addr, v.data);
        OP_KEY: begin key_stb = 1'b1; key_char = v.data; finish_cycle(); end
        OP_ACK: begin disp_ack = 1'b1; finish_cycle(); end
        default: begin
          bus_rd = 1'b1; bus_addr = v.addr;
          #1;
          chk($sformatf("R%0d vec %0d rdata", v.req, i), bus_rdata, DW'(v.exp));
          chk($sformatf("R9 vec %0d irq", i), DW'(irq), DW'(v.exp_irq));
          finish_cycle();
        end
      endcase
    end

    // R6 display port carries the written character
    wr(2'd1, 8'hC3);
    #1 chk("R6 disp_char", DW'(disp_char), DW'(8'hC3));

    // R7 write and acknowledge in one cycle: write wins
    disp_ack = 1'b1;
    wr(2'd1, 8'h21);
    rd_chk("R7 ack vs write", 2'd2, 8'h00);
    disp_ack = 1'b1;
    finish_cycle();
    rd_chk("R7 ack alone", 2'd2, 8'h01);

    // R5 strobe and receive read in one cycle
    key_stb = 1'b1; key_char = 8'h11;
    finish_cycle();
    key_stb = 1'b1; key_char = 8'h22;
    bus_rd = 1'b1; bus_addr = 2'd0;
    #1 chk("R5 old char returned", bus_rdata, DW'(8'h11));
    finish_cycle();
    rd_chk("R5 flag kept", 2'd2, 8'h03);
    rd_chk("R5 new char", 2'd0, 8'h22);
    rd_chk("R4 flag cleared", 2'd2, 8'h01);

    // R1 reset in mid-run returns every flag to its reset value
    key_stb = 1'b1; key_char = 8'h33;
    finish_cycle();
    wr(2'd2, 8'h40);
    wr(2'd1, 8'h44);
    #1 chk("R9 irq before reset", DW'(irq), DW'(1));
    do_reset();
    #1 chk("R1 irq after reset", DW'(irq), DW'(0));
    @(negedge clk);
    rd_chk("R1 status after reset", 2'd2, 8'h01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule